// File: doc/BRIEF.md
# Masked-Compare Memory Region Decoder

This block sits between a bus master and the memory system of a small processor subsystem. For each bus address it receives, it names the memory region that owns the address: boot RAM, external RAM 0, external RAM 1 or flash. It also gives the byte offset inside that region. A region claims an address when the address bits kept by the region's window mask equal the same bits of the region's base. The offset is the address's low window bits reduced modulo the region size. A region smaller than its window therefore repeats throughout the window.

Two complete memory maps are built in. A map-select pin is captured while reset is held, and the captured map stays in force until the next reset. The boot region is read-only. The fixed I/O page pair is reported separately from memory, and any other address is reported as a bus error.

Requests enter on a valid/ready port, and results leave one cycle later on a second valid/ready port that holds a single result. The block accepts a request when `in_valid_i` and `in_ready_o` are both high at a clock edge. `in_ready_o` is high whenever the output slot is empty or is being taken on the same edge. While `out_valid_o` is high and `out_ready_i` is low, every result field holds its value.

Top module: `addr_region_decoder`

## Requirements
- R1: Region codes are 0 for boot, 1 for RAM 0, 2 for RAM 1 and 3 for flash, and they are examined in that order; the first match wins. A region matches when address AND 0xF800_0000 equals its base AND 0xF800_0000. The map 0 bases are 0xBFC0_0000 (boot), 0x0000_0000 (RAM 0), 0x8000_0000 (RAM 1) and 0xB000_0000 (flash).
- R2: The offset equals address bits [26:0] modulo the selected region's size. This result is exact for sizes that are not powers of two. In map 0 the sizes are 0x4800, 0x8_0000, 0x8_0000 and 0x4_0000, so 0xBFC0_0000 gives boot offset 0x1000 and 0xBFC0_0180 gives 0x1180.
- R3: An address one region size above another address in the same window gives the same offset (mirroring).
- R4: A region configured with size zero never matches, and its addresses fall through to the later checks.
- R5: A read that hits boot gives hit=1. A write that hits boot gives prot=1 and hit=0, with region code 0 and the offset still reported.
- R6: An address whose upper 16 bits are 0x2000 or 0x2001, and that no region matches, gives io=1, hit=0, bus error 0, region code 4 and offset 0.
- R7: An address matched by no region and outside the I/O pages gives buserr=1, region code 4 and offset 0. Each result has exactly one of hit, prot, io and buserr set.
- R8: The map is captured from `map_sel_i` on every clock edge while `rst_n` is low. Later changes of `map_sel_i` have no effect until the next reset.
- R9: Map 1 exchanges the RAM bases, so RAM 0 sits at 0x8000_0000 and RAM 1 at 0x0000_0000. Its sizes are 0x1000 (boot), 0x20_0000 (RAM 0), 0x40_0000 (RAM 1) and 0x10_0000 (flash).
- R10: An accepted request gives `out_valid_o` on the next cycle. `in_ready_o` equals `!out_valid_o || out_ready_i`. Outputs hold while the consumer stalls, and results leave in request order.
- R11: During reset `out_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; the map is captured while it is low |
| map_sel_i | input | 1 | Memory map choice (0 or 1), captured during reset |
| in_valid_i | input | 1 | Request present |
| in_ready_o | output | 1 | Request can be taken this cycle |
| in_addr_i | input | 32 | Bus byte address |
| in_write_i | input | 1 | 1 for a write access, 0 for a read |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| out_region_o | output | 3 | Region code 0..3, or 4 for none |
| out_offset_o | output | 27 | Mirrored byte offset inside the region |
| out_hit_o | output | 1 | Access forwarded to the region |
| out_prot_o | output | 1 | Write to the read-only region |
| out_io_o | output | 1 | Address lies in the I/O pages |
| out_buserr_o | output | 1 | No target for the address |

## Verification
The embedded assertions cover the properties that hold on every cycle. Results are steady while the consumer stalls, and an accepted request always shows up on the next cycle. Every result carries exactly one outcome, and that outcome agrees with its region code. The captured map never changes outside reset, and every modulo result stays below its region size. The scoreboard scenarios alone can show that the decoded values are correct: the offsets for non-power-of-two sizes, mirroring, and the swapped bases of the second map. The same is true of the write protection on boot, the I/O and bus-error split, the fall-through of a zero-sized region, and the fact that `map_sel_i` is ignored after reset.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned NUM_REGIONS = 4;
  localparam int unsigned NUM_MAPS    = 2;
  localparam int unsigned REGION_W    = $clog2(NUM_REGIONS + 1);
  localparam logic [ADDR_W-1:0] WIN_MASK = 32'hF800_0000;
  localparam int unsigned OFF_W       = ADDR_W - $countones(WIN_MASK);
  localparam int unsigned IO_HI_W     = 16;
  localparam logic [IO_HI_W-1:0] IO_FIRST_PAGE = 16'h2000;
  localparam int unsigned IO_PAGES    = 2;

  typedef logic [REGION_W-1:0] region_idx_t;
  localparam region_idx_t REGION_NONE = region_idx_t'(NUM_REGIONS);

  typedef struct packed {
    region_idx_t       region;
    logic [OFF_W-1:0]  offset;
    logic              hit;
    logic              prot;
    logic              io;
    logic              buserr;
  } dec_result_t;

  // Base address of each region in each map; priority follows the index.
  function automatic logic [ADDR_W-1:0] region_base(input int map_id, input int idx);
    logic [ADDR_W-1:0] b;
    case (idx)
      0:       b = 32'hBFC0_0000;
      1:       b = (map_id == 0) ? 32'h0000_0000 : 32'h8000_0000;
      2:       b = (map_id == 0) ? 32'h8000_0000 : 32'h0000_0000;
      default: b = 32'hB000_0000;
    endcase
    return b;
  endfunction

  function automatic bit region_read_only(input int idx);
    return idx == 0;
  endfunction

  // Number of trailing zero bits of a size (zero for an empty size).
  function automatic int unsigned pow2_shift(input int unsigned s);
    int unsigned n;
    int unsigned v;
    n = 0;
    v = s;
    if (v != 0) begin
      while ((v & 1) == 0) begin
        v = v >> 1;
        n++;
      end
    end
    return n;
  endfunction

  function automatic int unsigned odd_factor(input int unsigned s);
    if (s == 0) return 1;
    return s >> pow2_shift(s);
  endfunction

endpackage

// File: rtl/region_modulo.sv
module region_modulo
  import addr_dec_pkg::*;
#(
  parameter int unsigned SIZE = 32'h4800,
  parameter int unsigned IN_W = OFF_W
) (
  input  logic [IN_W-1:0] win_off_i,
  output logic [IN_W-1:0] mod_o
);

  localparam int unsigned SHIFT = pow2_shift(SIZE);
  localparam int unsigned ODD   = odd_factor(SIZE);
  localparam logic [IN_W-1:0] LOW_MASK = IN_W'((64'd1 << SHIFT) - 64'd1);

  generate
    if (SIZE == 0) begin : g_empty
      assign mod_o = '0;
    end else if (ODD == 1) begin : g_pow2
      assign mod_o = win_off_i & LOW_MASK;
    end else begin : g_odd
      // Size = ODD * 2^SHIFT: reduce the upper part modulo ODD one bit at a time,
      // then reattach the untouched low SHIFT bits.
      localparam int unsigned RW = $clog2(2 * ODD);
      logic [RW-1:0] rem;

      always_comb begin
        rem = '0;
        for (int i = IN_W - 1; i >= int'(SHIFT); i--) begin
          rem = {rem[RW-2:0], win_off_i[i]};
          if (rem >= RW'(ODD)) rem = rem - RW'(ODD);
        end
        mod_o = (IN_W'(rem) << SHIFT) | (win_off_i & LOW_MASK);
      end
    end

    if (SIZE != 0) begin : g_chk
      always_comb begin
        assert_mod_range_R2: assert (mod_o < IN_W'(SIZE));
      end
    end
  endgenerate

endmodule

// File: rtl/region_slot.sv
module region_slot
  import addr_dec_pkg::*;
#(
  parameter int unsigned IDX     = 0,
  parameter int unsigned SIZE_M0 = 32'h4800,
  parameter int unsigned SIZE_M1 = 32'h1000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              map_i,
  output logic              match_o,
  output logic [OFF_W-1:0]  offset_o
);

  localparam logic [ADDR_W-1:0] BASE_M0 = region_base(0, IDX) & WIN_MASK;
  localparam logic [ADDR_W-1:0] BASE_M1 = region_base(1, IDX) & WIN_MASK;

  logic [OFF_W-1:0] off_m0, off_m1;
  logic [ADDR_W-1:0] base_sel;
  logic size_nz;

  region_modulo #(.SIZE(SIZE_M0), .IN_W(OFF_W)) u_mod_m0 (
    .win_off_i (addr_i[OFF_W-1:0]),
    .mod_o     (off_m0)
  );

  region_modulo #(.SIZE(SIZE_M1), .IN_W(OFF_W)) u_mod_m1 (
    .win_off_i (addr_i[OFF_W-1:0]),
    .mod_o     (off_m1)
  );

  always_comb begin
    base_sel = map_i ? BASE_M1 : BASE_M0;
    size_nz  = map_i ? (SIZE_M1 != 0) : (SIZE_M0 != 0);
    match_o  = size_nz && ((addr_i & WIN_MASK) == base_sel);
    offset_o = map_i ? off_m1 : off_m0;
  end

endmodule

// File: rtl/decode_out_reg.sv
module decode_out_reg
  import addr_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  dec_result_t d_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output dec_result_t q_o
);

  logic take;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign take       = in_valid_i && in_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid_o <= 1'b0;
    else if (in_ready_o) out_valid_o <= in_valid_i;
  end

  always_ff @(posedge clk) begin
    if (take) q_o <= d_i;
  end

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(q_o)));

  assert_accept_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ($countones({q_o.hit, q_o.prot, q_o.io, q_o.buserr}) == 1));

  assert_prot_on_boot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && q_o.prot) |-> (q_o.region == region_idx_t'(0)));

  assert_miss_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && (q_o.buserr || q_o.io)) |-> (q_o.region == REGION_NONE && q_o.offset == '0));

endmodule

// File: rtl/addr_region_decoder.sv
module addr_region_decoder
  import addr_dec_pkg::*;
#(
  parameter int unsigned BOOT_SIZE_M0  = 32'h0000_4800,
  parameter int unsigned RAM0_SIZE_M0  = 32'h0008_0000,
  parameter int unsigned RAM1_SIZE_M0  = 32'h0008_0000,
  parameter int unsigned FLASH_SIZE_M0 = 32'h0004_0000,
  parameter int unsigned BOOT_SIZE_M1  = 32'h0000_1000,
  parameter int unsigned RAM0_SIZE_M1  = 32'h0020_0000,
  parameter int unsigned RAM1_SIZE_M1  = 32'h0040_0000,
  parameter int unsigned FLASH_SIZE_M1 = 32'h0010_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                map_sel_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [ADDR_W-1:0]   in_addr_i,
  input  logic                in_write_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [REGION_W-1:0] out_region_o,
  output logic [OFF_W-1:0]    out_offset_o,
  output logic                out_hit_o,
  output logic                out_prot_o,
  output logic                out_io_o,
  output logic                out_buserr_o
);

  localparam int unsigned SIZES_M0 [NUM_REGIONS] =
    '{BOOT_SIZE_M0, RAM0_SIZE_M0, RAM1_SIZE_M0, FLASH_SIZE_M0};
  localparam int unsigned SIZES_M1 [NUM_REGIONS] =
    '{BOOT_SIZE_M1, RAM0_SIZE_M1, RAM1_SIZE_M1, FLASH_SIZE_M1};

  logic map_q;
  logic run_q;
  logic [NUM_REGIONS-1:0] slot_match;
  logic [OFF_W-1:0] slot_off [NUM_REGIONS];
  region_idx_t sel_idx;
  logic [OFF_W-1:0] sel_off;
  logic sel_ro;
  logic io_page;
  dec_result_t dec_d, dec_q;

  // Map choice is loaded only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) map_q <= map_sel_i;
  end

  always_ff @(posedge clk) begin
    run_q <= rst_n;
  end

  generate
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
      region_slot #(
        .IDX     (g),
        .SIZE_M0 (SIZES_M0[g]),
        .SIZE_M1 (SIZES_M1[g])
      ) u_slot (
        .addr_i   (in_addr_i),
        .map_i    (map_q),
        .match_o  (slot_match[g]),
        .offset_o (slot_off[g])
      );
    end
  endgenerate

  // Lowest index wins: scan from the back so earlier regions overwrite.
  always_comb begin
    sel_idx = REGION_NONE;
    sel_off = '0;
    sel_ro  = 1'b0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (slot_match[i]) begin
        sel_idx = region_idx_t'(i);
        sel_off = slot_off[i];
        sel_ro  = region_read_only(i);
      end
    end
  end

  assign io_page = (in_addr_i[ADDR_W-1 -: IO_HI_W] - IO_FIRST_PAGE) < IO_HI_W'(IO_PAGES);

  always_comb begin
    dec_d = '0;
    if (sel_idx != REGION_NONE) begin
      dec_d.region = sel_idx;
      dec_d.offset = sel_off;
      dec_d.prot   = in_write_i && sel_ro;
      dec_d.hit    = !(in_write_i && sel_ro);
    end else begin
      dec_d.region = REGION_NONE;
      dec_d.io     = io_page;
      dec_d.buserr = !io_page;
    end
  end

  decode_out_reg u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .d_i         (dec_d),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .q_o         (dec_q)
  );

  assign out_region_o = dec_q.region;
  assign out_offset_o = dec_q.offset;
  assign out_hit_o    = dec_q.hit;
  assign out_prot_o   = dec_q.prot;
  assign out_io_o     = dec_q.io;
  assign out_buserr_o = dec_q.buserr;

  assert_map_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> $stable(map_q));

endmodule

// File: tb/test_addr_region_decoder.sv
module test_addr_region_decoder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic map_sel = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic in_write = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [2:0] out_region;
  logic [26:0] out_offset;
  logic out_hit, out_prot, out_io, out_buserr;
  logic z_ready, z_valid;
  logic [2:0] z_region;
  logic [26:0] z_offset;
  logic z_hit, z_prot, z_io, z_buserr;

  int checks = 0;
  int fails = 0;
  bit exp_map1 = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic [2:0]  region;
    logic [26:0] offset;
    logic        hit, prot, io, buserr;
    logic [2:0]  z_region;
    logic        z_buserr;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  addr_region_decoder i_addr_region_decoder (
    .clk (clk), .rst_n (rst_n), .map_sel_i (map_sel),
    .in_valid_i (in_valid), .in_ready_o (in_ready),
    .in_addr_i (in_addr), .in_write_i (in_write),
    .out_valid_o (out_valid), .out_ready_i (out_ready),
    .out_region_o (out_region), .out_offset_o (out_offset),
    .out_hit_o (out_hit), .out_prot_o (out_prot),
    .out_io_o (out_io), .out_buserr_o (out_buserr)
  );

  // Second copy with map 0 RAM 1 disabled (size zero), for R4.
  addr_region_decoder #(.RAM1_SIZE_M0(0)) i_addr_region_decoder_z (
    .clk (clk), .rst_n (rst_n), .map_sel_i (map_sel),
    .in_valid_i (in_valid), .in_ready_o (z_ready),
    .in_addr_i (in_addr), .in_write_i (in_write),
    .out_valid_o (z_valid), .out_ready_i (out_ready),
    .out_region_o (z_region), .out_offset_o (z_offset),
    .out_hit_o (z_hit), .out_prot_o (z_prot),
    .out_io_o (z_io), .out_buserr_o (z_buserr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] a, input logic wr, input bit m1, input bit ram1_off, input string tag);
    exp_t e;
    logic [31:0] base [4];
    int unsigned sz [4];
    int hit_i;
    hit_i = -1;
    base = m1 ? '{32'hBFC00000, 32'h80000000, 32'h00000000, 32'hB0000000}
              : '{32'hBFC00000, 32'h00000000, 32'h80000000, 32'hB0000000};
    sz   = m1 ? '{32'h1000, 32'h200000, 32'h400000, 32'h100000}
              : '{32'h4800, 32'h80000, 32'h80000, 32'h40000};
    if (ram1_off && !m1) sz[2] = 0;
    for (int i = 0; i < 4; i++)
      if (hit_i < 0 && sz[i] != 0 && ((a & 32'hF8000000) == (base[i] & 32'hF8000000))) hit_i = i;
    e.addr = a; e.tag = tag;
    e.hit = 0; e.prot = 0; e.io = 0; e.buserr = 0; e.offset = '0; e.region = 3'd4;
    if (hit_i >= 0) begin
      e.region = 3'(hit_i);
      e.offset = 27'((a & 32'h07FFFFFF) % sz[hit_i]);
      e.prot = wr && hit_i == 0;
      e.hit  = !(wr && hit_i == 0);
    end else if (a[31:16] == 16'h2000 || a[31:16] == 16'h2001) e.io = 1;
    else e.buserr = 1;
    return e;
  endfunction

  task automatic send(input logic [31:0] a, input logic wr, input string tag);
    exp_t e, ez;
    e  = model(a, wr, exp_map1, 1'b0, tag);
    ez = model(a, wr, exp_map1, 1'b1, tag);
    e.z_region = ez.region;
    e.z_buserr = ez.buserr;
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_write = wr;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back(e);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst_n = 1'b0; map_sel = m; exp_map1 = m;
    repeat (2) @(negedge clk);
    #3;
    check(out_valid == 1'b0, "R11 out_valid in reset", 32'(out_valid), 0);
    check(in_ready == 1'b1, "R11 in_ready in reset", 32'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: set out_ready at the falling edge, compare just after.
  bit stalled = 0;
  logic [33:0] snap;
  bit ready_always = 1'b1;
  initial begin
    forever begin
      @(negedge clk);
      out_ready = ready_always ? 1'b1 : ($urandom % 3 != 0);
      #2;
      if (rst_n && stalled) begin
        check(out_valid && {out_region, out_offset, out_hit, out_prot, out_io, out_buserr} == snap,
              "R10 stall hold", 32'(out_offset), 32'(snap[30:4]));
      end
      stalled = rst_n && out_valid && !out_ready;
      snap = {out_region, out_offset, out_hit, out_prot, out_io, out_buserr};
      if (rst_n && out_valid && out_ready) begin
        if (sb.size() == 0) check(1'b0, "R10 unexpected result", 32'(out_region), 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(out_region == e.region, {e.tag, " region"}, 32'(out_region), 32'(e.region));
          check(out_offset == e.offset, {e.tag, " offset"}, 32'(out_offset), 32'(e.offset));
          check({out_hit, out_prot, out_io, out_buserr} == {e.hit, e.prot, e.io, e.buserr},
                {e.tag, " flags"}, 32'({out_hit, out_prot, out_io, out_buserr}),
                32'({e.hit, e.prot, e.io, e.buserr}));
          check(z_valid && z_region == e.z_region && z_buserr == e.z_buserr,
                {e.tag, " zero-size copy"}, 32'({z_region, z_buserr}), 32'({e.z_region, e.z_buserr}));
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    do_reset(1'b0);
    // Map 0 decoding
    send(32'hB8000000, 0, "R1 boot window start");
    send(32'hBFC00000, 0, "R2 reset vector offset");
    send(32'hBFC00180, 0, "R2 trap vector offset");
    send(32'hBFC04800, 0, "R3 boot mirror");
    send(32'h00000010, 0, "R1 ram0 read");
    send(32'h00080010, 1, "R3 ram0 mirror write");
    send(32'h80012345, 0, "R4 ram1 hit / zero-size miss");
    send(32'hB0001234, 1, "R1 flash write");
    send(32'hB0040004, 0, "R3 flash mirror");
    send(32'hBFC00000, 1, "R5 boot write protect");
    send(32'hBFC00004, 0, "R5 boot read allowed");
    send(32'h20000000, 0, "R6 io page 0");
    send(32'h2001FFFC, 1, "R6 io page 1");
    send(32'h20020000, 0, "R7 above io pages");
    send(32'h1FFFFFFC, 0, "R7 below io pages");
    send(32'h40000000, 1, "R7 unmapped");
    // Back-pressure burst, R10 ordering
    ready_always = 1'b0;
    for (int k = 0; k < 40; k++) begin
      logic [31:0] pick [8];
      pick = '{32'hBFC01234, 32'h00012340, 32'h8007FFFC, 32'hB003FFF0,
               32'h20001000, 32'h60000000, 32'hBFFFFFFF, 32'h07FFFFFF};
      send(pick[k % 8] + 32'(k * 4), 1'(k % 3 == 0), "R10 burst");
    end
    drain();
    ready_always = 1'b1;
    // Map 1
    do_reset(1'b1);
    send(32'h80002400, 0, "R9 map1 ram0");
    send(32'h00123456, 1, "R9 map1 ram1");
    send(32'h00400010, 0, "R9 map1 ram1 mirror");
    send(32'hBFC00000, 0, "R9 map1 boot size");
    send(32'hB0100008, 0, "R9 map1 flash mirror");
    send(32'h80012345, 0, "R4 map1 ram1-base now ram0");
    drain();
    map_sel = 1'b0;
    repeat (3) @(negedge clk);
    send(32'h80002400, 0, "R8 map held after select change");
    send(32'h00000010, 0, "R8 ram1 still at zero");
    drain();
    // Back to map 0 through reset
    do_reset(1'b0);
    send(32'h80002400, 0, "R8 map0 after new reset");
    drain();
    finish_run();
  end

endmodule